// File: doc/BRIEF.md
# Shared SPI PHY Port Arbiter

This block lets several stream masters take turns on a single SPI PHY. Examples are a memory-mapped flash reader, a CPU-driven command master, a reader for the flash identity, and a write engine. Each master has three things: a command stream (valid, ready, data, last), a response stream (valid, ready, data), and a lock line. The arbiter keeps one owner at a time. It steers the owner's command stream to the PHY and the PHY's response stream back to the owner only. Every other port sees its ready and its response valid held low.

Ownership does not follow stream framing or chip select. In automatic mode the owner keeps the PHY for as long as it holds its lock, and it may send any number of complete commands in that time. When the lock drops, the next requester in circular order takes over. In forced mode a software select bit picks the owner. Port 1, the CPU master, is chosen when the bit is one. Port 0, the memory-mapped reader, is chosen when the bit is zero. The owner changes only on a clock edge where the PHY reports idle and no command is part-way through. When the block is built with a single port, it becomes plain wiring with no state.

Top module: `spi_port_arbiter`

## Requirements
- R1: After reset, port 0 owns the PHY: grant_oh is one-hot, bit i means port i owns it, and grant_oh equals 1 after reset.
- R2: In forced mode (auto_mode = 0), the owner moves to port 1 when sw_cpu_sel = 1, and to port 0 when sw_cpu_sel = 0, on the first edge where a change is allowed. Lock lines have no effect in this mode.
- R3: In automatic mode (auto_mode = 1), the owner keeps the grant on every edge where its own lock line is high, however many commands with last = 1 it sends in that time.
- R4: In automatic mode, at an allowed edge where the owner's lock line is low, the grant passes to the first port with its lock line high, searching upward from owner+1 and wrapping. If no lock line is high, the grant stays where it is.
- R5: The grant never changes on an edge where phy_idle is low.
- R6: After a command beat with last = 0 is accepted, the grant is frozen through the edge where the beat with last = 1 is accepted. No change happens on any edge where a command beat is accepted.
- R7: phy_cmd_valid, phy_cmd_data and phy_cmd_last copy the owner's command stream. The owner's cmd_ready equals phy_cmd_ready, and every other cmd_ready bit is 0.
- R8: rsp_valid is nonzero only at the owner's bit, and there it equals phy_rsp_valid. phy_rsp_ready equals the owner's rsp_ready. rsp_data carries phy_rsp_data.
- R9: With NPORTS = 1, the single port is wired straight to the PHY in both directions, grant_oh is 1, and the lock, mode and select inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_mode | input | 1 | 1 = round-robin on locks, 0 = software forced |
| sw_cpu_sel | input | 1 | Forced owner: 1 = CPU port 1, 0 = memory-mapped port 0 |
| port_lock | input | NPORTS | Per-port request/lock line |
| cmd_valid | input | NPORTS | Per-port command valid |
| cmd_ready | output | NPORTS | Per-port command ready |
| cmd_data | input | NPORTS*CMD_W | Per-port command payload, port i at bits i*CMD_W upward |
| cmd_last | input | NPORTS | Per-port command end marker |
| rsp_valid | output | NPORTS | Per-port response valid |
| rsp_ready | input | NPORTS | Per-port response ready |
| rsp_data | output | RSP_W | Response payload shared by all ports |
| phy_cmd_valid | output | 1 | Command valid to the PHY |
| phy_cmd_ready | input | 1 | Command ready from the PHY |
| phy_cmd_data | output | CMD_W | Command payload to the PHY |
| phy_cmd_last | output | 1 | Command end marker to the PHY |
| phy_rsp_valid | input | 1 | Response valid from the PHY |
| phy_rsp_ready | output | 1 | Response ready to the PHY |
| phy_rsp_data | input | RSP_W | Response payload from the PHY |
| phy_idle | input | 1 | PHY reports no transfer running |
| grant_oh | output | NPORTS | One-hot current owner |

## Verification
Two events can fall on the same edge, and this is where the block is most likely to go wrong. One is an owner releasing its lock, or software changing the select bit. The other is a command beat being accepted or the PHY going busy. A directed sequence drops the owner's lock while a competitor requests and phy_idle stays high. It then sends a two-beat command, which checks that the grant holds on the accepting edges and moves on the first quiet edge. Random phases in both modes toggle locks, the select bit, phy_idle, handshakes and last flags every cycle. A behavioural owner-and-packet model in the bench judges the grant and all routed signals on every cycle.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
    localparam int unsigned MMAP_PORT = 0;
    localparam int unsigned CPU_PORT  = 1;

    typedef enum logic {
        SEL_MMAP = 1'b0,
        SEL_CPU  = 1'b1
    } sw_sel_e;
endpackage

// File: rtl/spi_arb_xfer_track.sv
// Remembers whether a multi-beat command is open and reports when a switch
// of owner would cut into traffic.
module spi_arb_xfer_track (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic last,
    output logic busy
);
    typedef struct packed {
        logic open;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.open = ~last;
        end
        busy = st_q.open | fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_arb_rr_pick.sv
// Circular search for the next requester, starting just after the owner.
module spi_arb_rr_pick #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [IDX_W-1:0]  cur,
    input  logic [NPORTS-1:0] req,
    output logic              found,
    output logic [IDX_W-1:0]  nxt
);
    always_comb begin
        found = 1'b0;
        nxt   = cur;
        for (int k = 1; k <= int'(NPORTS); k++) begin
            if (!found && req[(int'(cur) + k) % int'(NPORTS)]) begin
                found = 1'b1;
                nxt   = IDX_W'((int'(cur) + k) % int'(NPORTS));
            end
        end
    end
endmodule

// File: rtl/spi_arb_route.sv
// Steers the owner's streams to and from the PHY; others are gated off.
module spi_arb_route #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned CMD_W  = 32,
    parameter int unsigned RSP_W  = 32
) (
    input  logic [IDX_W-1:0]        grant,
    input  logic [NPORTS-1:0]       cmd_valid,
    output logic [NPORTS-1:0]       cmd_ready,
    input  logic [NPORTS*CMD_W-1:0] cmd_data,
    input  logic [NPORTS-1:0]       cmd_last,
    output logic [NPORTS-1:0]       rsp_valid,
    input  logic [NPORTS-1:0]       rsp_ready,
    output logic [RSP_W-1:0]        rsp_data,
    output logic                    phy_cmd_valid,
    input  logic                    phy_cmd_ready,
    output logic [CMD_W-1:0]        phy_cmd_data,
    output logic                    phy_cmd_last,
    input  logic                    phy_rsp_valid,
    output logic                    phy_rsp_ready,
    input  logic [RSP_W-1:0]        phy_rsp_data
);
    always_comb begin
        phy_cmd_valid = cmd_valid[grant];
        phy_cmd_last  = cmd_last[grant];
        phy_cmd_data  = cmd_data[int'(grant)*int'(CMD_W) +: CMD_W];
        phy_rsp_ready = rsp_ready[grant];
        rsp_data      = phy_rsp_data;
        for (int i = 0; i < int'(NPORTS); i++) begin
            cmd_ready[i] = (grant == IDX_W'(i)) & phy_cmd_ready;
            rsp_valid[i] = (grant == IDX_W'(i)) & phy_rsp_valid;
        end
    end
endmodule

// File: rtl/spi_port_arbiter.sv
module spi_port_arbiter #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned CMD_W  = 32,
    parameter int unsigned RSP_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    auto_mode,
    input  logic                    sw_cpu_sel,
    input  logic [NPORTS-1:0]       port_lock,
    input  logic [NPORTS-1:0]       cmd_valid,
    output logic [NPORTS-1:0]       cmd_ready,
    input  logic [NPORTS*CMD_W-1:0] cmd_data,
    input  logic [NPORTS-1:0]       cmd_last,
    output logic [NPORTS-1:0]       rsp_valid,
    input  logic [NPORTS-1:0]       rsp_ready,
    output logic [RSP_W-1:0]        rsp_data,
    output logic                    phy_cmd_valid,
    input  logic                    phy_cmd_ready,
    output logic [CMD_W-1:0]        phy_cmd_data,
    output logic                    phy_cmd_last,
    input  logic                    phy_rsp_valid,
    output logic                    phy_rsp_ready,
    input  logic [RSP_W-1:0]        phy_rsp_data,
    input  logic                    phy_idle,
    output logic [NPORTS-1:0]       grant_oh
);
    import spi_arb_pkg::*;

    localparam int unsigned IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    generate
        if (NPORTS == 1) begin : g_direct
            // One master: plain wiring, no arbitration state.
            assign phy_cmd_valid = cmd_valid[0];
            assign phy_cmd_data  = cmd_data;
            assign phy_cmd_last  = cmd_last[0];
            assign cmd_ready     = phy_cmd_ready;
            assign rsp_valid     = phy_rsp_valid;
            assign phy_rsp_ready = rsp_ready[0];
            assign rsp_data      = phy_rsp_data;
            assign grant_oh      = 1'b1;
        end else begin : g_shared
            typedef struct packed {
                logic [IDX_W-1:0] grant;
            } arb_state_t;

            arb_state_t       st_d, st_q;
            logic             xfer_busy;
            logic             may_switch;
            logic             rr_found;
            logic [IDX_W-1:0] rr_next;
            logic [IDX_W-1:0] forced_idx;
            sw_sel_e          sel;

            spi_arb_xfer_track u_track (
                .clk   (clk),
                .rst_n (rst_n),
                .fire  (phy_cmd_valid & phy_cmd_ready),
                .last  (phy_cmd_last),
                .busy  (xfer_busy)
            );

            spi_arb_rr_pick #(
                .NPORTS (NPORTS),
                .IDX_W  (IDX_W)
            ) u_pick (
                .cur   (st_q.grant),
                .req   (port_lock),
                .found (rr_found),
                .nxt   (rr_next)
            );

            spi_arb_route #(
                .NPORTS (NPORTS),
                .IDX_W  (IDX_W),
                .CMD_W  (CMD_W),
                .RSP_W  (RSP_W)
            ) u_route (
                .grant         (st_q.grant),
                .cmd_valid     (cmd_valid),
                .cmd_ready     (cmd_ready),
                .cmd_data      (cmd_data),
                .cmd_last      (cmd_last),
                .rsp_valid     (rsp_valid),
                .rsp_ready     (rsp_ready),
                .rsp_data      (rsp_data),
                .phy_cmd_valid (phy_cmd_valid),
                .phy_cmd_ready (phy_cmd_ready),
                .phy_cmd_data  (phy_cmd_data),
                .phy_cmd_last  (phy_cmd_last),
                .phy_rsp_valid (phy_rsp_valid),
                .phy_rsp_ready (phy_rsp_ready),
                .phy_rsp_data  (phy_rsp_data)
            );

            always_comb begin
                sel        = sw_sel_e'(sw_cpu_sel);
                forced_idx = (sel == SEL_CPU) ? IDX_W'(CPU_PORT) : IDX_W'(MMAP_PORT);
                may_switch = phy_idle & ~xfer_busy;
                st_d       = st_q;
                if (may_switch) begin
                    if (!auto_mode) begin
                        st_d.grant = forced_idx;
                    end else if (!port_lock[st_q.grant] && rr_found) begin
                        st_d.grant = rr_next;
                    end
                end
                for (int i = 0; i < int'(NPORTS); i++) begin
                    grant_oh[i] = (st_q.grant == IDX_W'(i));
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q.grant <= IDX_W'(MMAP_PORT);
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/spi_port_arbiter_chk.sv
module spi_port_arbiter_chk #(
    parameter int unsigned NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_mode,
    input logic [NPORTS-1:0] port_lock,
    input logic [NPORTS-1:0] cmd_ready,
    input logic [NPORTS-1:0] rsp_valid,
    input logic              phy_cmd_valid,
    input logic              phy_cmd_ready,
    input logic              phy_cmd_last,
    input logic              phy_rsp_valid,
    input logic              phy_idle,
    input logic [NPORTS-1:0] grant_oh
);
    // R7: no port outside the grant may see ready
    a_r7_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready & ~grant_oh) == '0);

    // R8: responses reach the owner only
    a_r8_rsp_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == (phy_rsp_valid ? grant_oh : '0));

    // R3: owner holding its lock keeps the grant
    a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && |(port_lock & grant_oh)) |=> $stable(grant_oh));

    // R5: busy PHY freezes ownership
    a_r5_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_idle |=> $stable(grant_oh));

    // R6: an open command freezes ownership
    a_r6_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cmd_valid && phy_cmd_ready && !phy_cmd_last) |=> $stable(grant_oh));

    // R1: exactly one owner at every checked edge
    a_r1_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_oh) == 1);
endmodule

bind spi_port_arbiter spi_port_arbiter_chk #(.NPORTS(NPORTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .auto_mode     (auto_mode),
    .port_lock     (port_lock),
    .cmd_ready     (cmd_ready),
    .rsp_valid     (rsp_valid),
    .phy_cmd_valid (phy_cmd_valid),
    .phy_cmd_ready (phy_cmd_ready),
    .phy_cmd_last  (phy_cmd_last),
    .phy_rsp_valid (phy_rsp_valid),
    .phy_idle      (phy_idle),
    .grant_oh      (grant_oh)
);

// File: tb/spi_port_arbiter_tb_top.sv
module spi_port_arbiter_tb_top;
    localparam int N  = 4;
    localparam int CW = 32;
    localparam int RW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            auto_mode, sw_cpu_sel;
    logic [N-1:0]    port_lock, cmd_valid, cmd_ready, cmd_last, rsp_valid, rsp_ready, grant_oh;
    logic [N*CW-1:0] cmd_data;
    logic [RW-1:0]   rsp_data, phy_rsp_data;
    logic            phy_cmd_valid, phy_cmd_ready, phy_cmd_last, phy_rsp_valid, phy_rsp_ready, phy_idle;
    logic [CW-1:0]   phy_cmd_data;

    // single-port build
    logic          s_cmd_ready, s_rsp_valid, s_phy_cmd_valid, s_phy_cmd_last, s_phy_rsp_ready, s_grant;
    logic [CW-1:0] s_phy_cmd_data;
    logic [RW-1:0] s_rsp_data;

    spi_port_arbiter #(.NPORTS(N), .CMD_W(CW), .RSP_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .sw_cpu_sel(sw_cpu_sel),
        .port_lock(port_lock), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_last(cmd_last), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .phy_cmd_valid(phy_cmd_valid),
        .phy_cmd_ready(phy_cmd_ready), .phy_cmd_data(phy_cmd_data),
        .phy_cmd_last(phy_cmd_last), .phy_rsp_valid(phy_rsp_valid),
        .phy_rsp_ready(phy_rsp_ready), .phy_rsp_data(phy_rsp_data),
        .phy_idle(phy_idle), .grant_oh(grant_oh));

    spi_port_arbiter #(.NPORTS(1), .CMD_W(CW), .RSP_W(RW)) dut1_i (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .sw_cpu_sel(sw_cpu_sel),
        .port_lock(port_lock[1]), .cmd_valid(cmd_valid[1]), .cmd_ready(s_cmd_ready),
        .cmd_data(cmd_data[CW +: CW]), .cmd_last(cmd_last[1]), .rsp_valid(s_rsp_valid),
        .rsp_ready(rsp_ready[1]), .rsp_data(s_rsp_data), .phy_cmd_valid(s_phy_cmd_valid),
        .phy_cmd_ready(phy_cmd_ready), .phy_cmd_data(s_phy_cmd_data),
        .phy_cmd_last(s_phy_cmd_last), .phy_rsp_valid(phy_rsp_valid),
        .phy_rsp_ready(s_phy_rsp_ready), .phy_rsp_data(phy_rsp_data),
        .phy_idle(phy_idle), .grant_oh(s_grant));

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    int  m_grant;   // model owner
    bit  m_open;    // model: multi-beat command open
    string gtag;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [N-1:0] oh;
        oh = N'(1) << m_grant;
        chk(gtag, "grant_oh", 64'(grant_oh), 64'(oh));
        chk("R7", "phy_cmd_valid", 64'(phy_cmd_valid), 64'(cmd_valid[m_grant]));
        chk("R7", "phy_cmd_last", 64'(phy_cmd_last), 64'(cmd_last[m_grant]));
        chk("R7", "phy_cmd_data", 64'(phy_cmd_data), 64'(cmd_data[m_grant*CW +: CW]));
        chk("R7", "cmd_ready", 64'(cmd_ready), 64'(phy_cmd_ready ? oh : '0));
        chk("R8", "rsp_valid", 64'(rsp_valid), 64'(phy_rsp_valid ? oh : '0));
        chk("R8", "phy_rsp_ready", 64'(phy_rsp_ready), 64'(rsp_ready[m_grant]));
        chk("R8", "rsp_data", 64'(rsp_data), 64'(phy_rsp_data));
        chk("R9", "single valid", 64'(s_phy_cmd_valid), 64'(cmd_valid[1]));
        chk("R9", "single data", 64'(s_phy_cmd_data), 64'(cmd_data[CW +: CW]));
        chk("R9", "single last", 64'(s_phy_cmd_last), 64'(cmd_last[1]));
        chk("R9", "single ready", 64'(s_cmd_ready), 64'(phy_cmd_ready));
        chk("R9", "single rsp", 64'({s_rsp_valid, s_phy_rsp_ready, s_grant}),
            64'({phy_rsp_valid, rsp_ready[1], 1'b1}));
    endtask

    // inputs already applied after a falling edge
    task automatic step();
        bit fire, allow;
        int nxt;
        #1;
        compare();
        fire  = cmd_valid[m_grant] && phy_cmd_ready;
        allow = phy_idle && !m_open && !fire;
        nxt   = m_grant;
        if (allow) begin
            if (!auto_mode) nxt = sw_cpu_sel ? 1 : 0;
            else if (!port_lock[m_grant]) begin
                for (int k = 1; k <= N; k++) begin
                    if (port_lock[(m_grant + k) % N]) begin
                        nxt = (m_grant + k) % N;
                        break;
                    end
                end
            end
        end
        @(posedge clk);
        if (fire) m_open = !cmd_last[m_grant];
        m_grant = nxt;
        @(negedge clk);
    endtask

    task automatic rand_inputs(bit auto_phase);
        auto_mode = auto_phase;
        if ($urandom_range(7) == 0) sw_cpu_sel = ~sw_cpu_sel;
        for (int i = 0; i < N; i++) if ($urandom_range(5) == 0) port_lock[i] = ~port_lock[i];
        cmd_valid     = N'($urandom);
        cmd_last      = N'($urandom);
        rsp_ready     = N'($urandom);
        for (int i = 0; i < N; i++) cmd_data[i*CW +: CW] = $urandom;
        phy_cmd_ready = ($urandom_range(3) != 0);
        phy_rsp_valid = $urandom_range(1);
        phy_rsp_data  = $urandom;
        phy_idle      = ($urandom_range(9) < 7);
    endtask

    task automatic quiet();
        cmd_valid = '0; cmd_last = '0; phy_cmd_ready = 1'b1; phy_idle = 1'b1;
        phy_rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; auto_mode = 1'b1; sw_cpu_sel = 1'b0; port_lock = '0;
        cmd_data = '0; rsp_ready = '0; phy_rsp_data = '0;
        quiet();
        m_grant = 0; m_open = 0;
        repeat (3) @(negedge clk);
        #1 chk("R1", "grant in reset", 64'(grant_oh), 64'h1);
        rst_n = 1'b1;
        @(negedge clk);
        gtag = "R1";
        step();

        // R4: owner 0 idle, port 2 requests; R6: beats block the move
        gtag = "R4 R5 R6";
        port_lock = 4'b0100;
        cmd_valid = 4'b0001; cmd_last = 4'b0000; step();   // open beat, fire blocks
        chk("R6", "hold on open beat", 64'(grant_oh), 64'h1);
        cmd_valid = 4'b0000; step();                       // open command blocks
        chk("R6", "hold while open", 64'(grant_oh), 64'h1);
        cmd_valid = 4'b0001; cmd_last = 4'b0001; step();   // closing beat blocks
        chk("R6", "hold on last beat", 64'(grant_oh), 64'h1);
        quiet(); phy_idle = 1'b0; step();
        chk("R5", "hold while PHY busy", 64'(grant_oh), 64'h1);
        phy_idle = 1'b1; step();
        chk("R4", "move to requester", 64'(grant_oh), 64'h4);

        // R3: several whole commands under lock, competitor waiting
        gtag = "R3";
        port_lock = 4'b1100;
        for (int j = 0; j < 4; j++) begin
            cmd_valid = 4'b0100; cmd_last = 4'b0100; step();
        end
        chk("R3", "lock kept across commands", 64'(grant_oh), 64'h4);
        quiet(); port_lock = 4'b0011; step();
        chk("R4", "wrap to port 0", 64'(grant_oh), 64'h1);
        port_lock = 4'b0000; step(); step();
        chk("R4", "park without requests", 64'(grant_oh), 64'h1);

        // R2: forced ownership ignores locks
        gtag = "R2";
        auto_mode = 1'b0; sw_cpu_sel = 1'b1; port_lock = 4'b1001; step();
        chk("R2", "forced to CPU port", 64'(grant_oh), 64'h2);
        sw_cpu_sel = 1'b0; phy_idle = 1'b0; step();
        chk("R2", "forced waits for idle", 64'(grant_oh), 64'h2);
        phy_idle = 1'b1; step();
        chk("R2", "forced to mmap port", 64'(grant_oh), 64'h1);

        gtag = "R2 R5 R6";
        for (int c = 0; c < 1500; c++) begin rand_inputs(1'b0); step(); end
        gtag = "R3 R4 R5 R6";
        for (int c = 0; c < 2500; c++) begin rand_inputs(1'b1); step(); end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule